// File: doc/BRIEF.md
# Byte-Wide Configuration Serializer

This block is the device-side front end of a configuration loader. A host writes configuration bytes over a parallel valid/ready port. Each byte is turned into a serial stream, least significant bit first, at one bit per configuration clock. The stream is then parsed.

The parser checks a 40-bit header and takes a 24-bit length count from it. It then checks the framing of every data frame that follows. It counts emitted bits until the length count is met, then raises `done`, and one clock later releases the device outputs (`active`). Header bits are repeated on a daisy-chain output that updates on the falling clock edge.

The top bit of every byte is held back in the serializer and is emitted only in the first slot of the next byte. A host must therefore write one more byte when the last counted bit is a byte's top bit. A framing fault pulls `init_n` low for one clock and restarts the whole configuration cycle.

Top module: `cfg_serializer`

## Requirements
- R1: A byte is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only when no byte is being shifted and `init_n` is high. While `in_valid` is high and `in_ready` is low, the host must hold `in_valid` and `in_data` steady (back-pressure).
- R2: `busy` rises in the clock after a byte is accepted and stays high for exactly 8 clocks. After that, the next byte can be accepted.
- R3: Each accepted byte is emitted on `cfg_bit` with `cfg_bit_vld` high, least significant bit first, one bit per clock.
- R4: Bit 7 of a byte is not emitted during that byte's shifting. It is emitted in the first shifting slot of the next byte. After reset or an error, that first slot carries no bit (`cfg_bit_vld` low).
- R5: Emitted bits 0 to 7 must all be 1. Bits 8 to 11 must be 0,0,1,0, in that order. Any mismatch is a framing error.
- R6: Bits 12 to 35 carry the length count, least significant bit first. Bits 36 to 39 are not checked. The length count is the number of emitted bits counted from bit 0, and it must be at least 37.
- R7: From bit 40 on, the stream is split into frames of 266 bits that may straddle byte borders. Frame bit 0 must be 0, and the last 2 bits must be 1. A mismatch is a framing error.
- R8: `done` rises one clock after the edge that takes in the bit whose count equals the length count. `active` rises one clock after `done`. Both stay high until reset or an error. Bits after that point are not checked.
- R9: On a framing error, `init_n` is low for exactly one clock. The byte being shifted and the held bit are discarded, `done` and `active` clear, and parsing restarts at header bit 0.
- R10: Header bits 0 to 39 are repeated on `dout`, which updates on the falling edge half a clock after the bit appears on `cfg_bit`. Otherwise `dout` holds its value, and it is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host byte valid |
| in_ready | output | 1 | Serializer can accept a byte |
| in_data | input | 8 | Host configuration byte |
| busy | output | 1 | Byte shifting in progress |
| cfg_bit_vld | output | 1 | A configuration bit is emitted this cycle (no back-pressure) |
| cfg_bit | output | 1 | Emitted configuration bit |
| dout | output | 1 | Daisy-chain header copy, falling-edge timed |
| init_n | output | 1 | Low for one clock after a framing error |
| done | output | 1 | Length count reached |
| active | output | 1 | Device outputs released |

## Verification
Good streams are sent twice. One uses a length count that ends inside a byte. The other ends on a byte's top bit, so `done` must wait for an extra byte; this separates the held-bit behaviour from a plain serializer. Faulty streams each break a different check: a preamble bit, a sync bit, a frame start bit, and a frame stop bit in the second frame. A short good stream after the errors shows a clean restart. Gaps between host writes exercise the back-pressure rule, and a cycle-accurate model in the bench tracks every output on every clock.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;
  localparam int PRE_BITS  = 8;
  localparam int SYNC_BITS = 4;
  localparam int PAD_BITS  = 4;

  typedef enum logic [2:0] {
    SEG_PRE,
    SEG_SYNC,
    SEG_LEN,
    SEG_PAD,
    SEG_FRAME
  } seg_e;
endpackage

// File: rtl/cfgser_shift.sv
module cfgser_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              enable,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              busy,
  output logic              bit_vld,
  output logic              bit_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int IDX_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  step;
  logic [IDX_W-1:0]  sel;
  logic [BYTE_W-1:0] sh;
  logic              hold_bit, hold_vld;

  // step 0 emits the held top bit of the previous byte, steps 1.. emit bits 0..
  assign step     = CNT_W'(BYTE_W) - cnt;
  assign sel      = IDX_W'(step - CNT_W'(1));
  assign busy     = (cnt != '0);
  assign in_ready = (cnt == '0) && enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sh       <= '0;
      hold_bit <= 1'b0;
      hold_vld <= 1'b0;
      bit_vld  <= 1'b0;
      bit_o    <= 1'b0;
    end else if (clr) begin
      cnt      <= '0;
      hold_vld <= 1'b0;
      bit_vld  <= 1'b0;
    end else if (cnt != '0) begin
      if (step == '0) begin
        bit_vld <= hold_vld;
        bit_o   <= hold_bit;
      end else begin
        bit_vld <= 1'b1;
        bit_o   <= sh[sel];
      end
      if (cnt == CNT_W'(1)) begin
        hold_bit <= sh[BYTE_W-1];
        hold_vld <= 1'b1;
      end
      cnt <= cnt - CNT_W'(1);
    end else begin
      bit_vld <= 1'b0;
      if (in_valid && in_ready) begin
        sh  <= in_data;
        cnt <= CNT_W'(BYTE_W);
      end
    end
  end

  AST_BIT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> $past(busy)); // R3
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !clr) |=> busy); // R2
endmodule

// File: rtl/cfgser_parse.sv
module cfgser_parse
  import cfgser_pkg::*;
#(
  parameter int                   LEN_W      = 24,
  parameter int                   FRAME_BITS = 266,
  parameter int                   STOP_BITS  = 2,
  parameter logic [SYNC_BITS-1:0] SYNC_PAT   = 4'b0100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_i,
  output logic err_o,
  output logic init_n,
  output logic done,
  output logic active,
  output logic dout
);
  localparam int CNT_W    = LEN_W + 1;
  localparam int LEN_LO   = PRE_BITS + SYNC_BITS;
  localparam int PAD_LO   = LEN_LO + LEN_W;
  localparam int HDR_BITS = PAD_LO + PAD_BITS;
  localparam int FP_W     = $clog2(FRAME_BITS);
  localparam int LI_W     = $clog2(LEN_W);
  localparam int SI_W     = $clog2(SYNC_BITS);

  logic [CNT_W-1:0] bitcnt;
  logic [LEN_W-1:0] len_q;
  logic [FP_W-1:0]  fpos;
  logic [LI_W-1:0]  len_idx;
  logic [SI_W-1:0]  sync_idx;
  logic             reached_q, done_q, act_q, init_n_q, dout_q;
  logic             live, mismatch, hit;
  seg_e             seg;

  always_comb begin
    if (bitcnt < CNT_W'(PRE_BITS))      seg = SEG_PRE;
    else if (bitcnt < CNT_W'(LEN_LO))   seg = SEG_SYNC;
    else if (bitcnt < CNT_W'(PAD_LO))   seg = SEG_LEN;
    else if (bitcnt < CNT_W'(HDR_BITS)) seg = SEG_PAD;
    else                                seg = SEG_FRAME;
  end

  assign len_idx  = LI_W'(bitcnt - CNT_W'(LEN_LO));
  assign sync_idx = SI_W'(bitcnt - CNT_W'(PRE_BITS));

  always_comb begin
    case (seg)
      SEG_PRE:   mismatch = !bit_i;
      SEG_SYNC:  mismatch = (bit_i != SYNC_PAT[sync_idx]);
      SEG_FRAME: mismatch = ((fpos == '0) && bit_i) ||
                            ((fpos >= FP_W'(FRAME_BITS - STOP_BITS)) && !bit_i);
      default:   mismatch = 1'b0;
    endcase
  end

  assign live  = bit_vld && !reached_q;
  assign err_o = live && mismatch;
  assign hit   = live && !mismatch && (bitcnt >= CNT_W'(PAD_LO)) &&
                 ((bitcnt + CNT_W'(1)) == {1'b0, len_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt    <= '0;
      len_q     <= '0;
      fpos      <= '0;
      reached_q <= 1'b0;
      done_q    <= 1'b0;
      act_q     <= 1'b0;
      init_n_q  <= 1'b1;
    end else if (err_o) begin
      bitcnt    <= '0;
      len_q     <= '0;
      fpos      <= '0;
      reached_q <= 1'b0;
      done_q    <= 1'b0;
      act_q     <= 1'b0;
      init_n_q  <= 1'b0;
    end else begin
      init_n_q <= 1'b1;
      done_q   <= reached_q;
      act_q    <= done_q;
      if (live) begin
        bitcnt <= bitcnt + CNT_W'(1);
        if (seg == SEG_LEN) len_q[len_idx] <= bit_i;
        if (seg == SEG_FRAME)
          fpos <= (fpos == FP_W'(FRAME_BITS - 1)) ? '0 : fpos + FP_W'(1);
        if (hit) reached_q <= 1'b1;
      end
    end
  end

  // header copy for the next device, retimed to the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= 1'b1;
    else if (bit_vld && (bitcnt < CNT_W'(HDR_BITS))) dout_q <= bit_i;
  end

  assign init_n = init_n_q;
  assign done   = done_q;
  assign active = act_q;
  assign dout   = dout_q;

  AST_INIT_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n |=> init_n); // R9
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n |-> (!done && !active)); // R9
  AST_ACTIVE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(done)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R8
endmodule

// File: rtl/cfg_serializer.sv
module cfg_serializer #(
  parameter int         BYTE_W     = 8,
  parameter int         LEN_W      = 24,
  parameter int         FRAME_BITS = 266,
  parameter int         STOP_BITS  = 2,
  parameter logic [3:0] SYNC_PAT   = 4'b0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              busy,
  output logic              cfg_bit_vld,
  output logic              cfg_bit,
  output logic              dout,
  output logic              init_n,
  output logic              done,
  output logic              active
);
  logic err;

  cfgser_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (err),
    .enable   (init_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .busy     (busy),
    .bit_vld  (cfg_bit_vld),
    .bit_o    (cfg_bit)
  );

  cfgser_parse #(
    .LEN_W      (LEN_W),
    .FRAME_BITS (FRAME_BITS),
    .STOP_BITS  (STOP_BITS),
    .SYNC_PAT   (SYNC_PAT)
  ) u_parse (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_vld (cfg_bit_vld),
    .bit_i   (cfg_bit),
    .err_o   (err),
    .init_n  (init_n),
    .done    (done),
    .active  (active),
    .dout    (dout)
  );
endmodule

// File: tb/cfg_serializer_tb.sv
`timescale 1ns/1ps
module cfg_serializer_tb;
  localparam int FRAME = 266;
  localparam int SYNC  = 4'b0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, busy, cfg_bit_vld, cfg_bit, dout, init_n, done, active;

  always #2 clk = ~clk;

  cfg_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .busy(busy), .cfg_bit_vld(cfg_bit_vld), .cfg_bit(cfg_bit),
    .dout(dout), .init_n(init_n), .done(done), .active(active)
  );

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int q[$];
  int held;
  bit mv, mb;
  int nbits, mlen;
  bit mreached, mdone, mact, minit, mdout;
  bit err_seen, accepted, saw_low;
  int gb[$];

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    q.delete(); held = -1; mv = 0; mb = 0; nbits = 0; mlen = 0;
    mreached = 0; mdone = 0; mact = 0; minit = 1; mdout = 1;
  endtask

  task automatic model_step();
    bit rdy, acc, err, hit;
    int fp, s;
    rdy = (q.size() == 0) && minit;
    acc = in_valid && rdy;
    err = 0; hit = 0; accepted = 0;
    if (mv && !mreached) begin
      if (nbits < 8) err = (mb != 1);
      else if (nbits < 12) err = (mb != ((SYNC >> (nbits - 8)) & 1));
      else if (nbits < 36) mlen = mlen | (int'(mb) << (nbits - 12));
      else if (nbits >= 40) begin
        fp = (nbits - 40) % FRAME;
        if (fp == 0 && mb != 0) err = 1;
        if (fp >= FRAME - 2 && mb != 1) err = 1;
      end
      if (!err && nbits >= 36 && nbits + 1 == mlen) hit = 1;
    end
    if (err) begin
      q.delete(); held = -1; mv = 0; nbits = 0; mlen = 0;
      mreached = 0; mdone = 0; mact = 0; minit = 0; err_seen = 1;
    end else begin
      minit = 1;
      mact = mdone;
      mdone = mreached;
      if (mv && !mreached) nbits++;
      if (hit) mreached = 1;
      if (q.size() > 0) begin
        s = q.pop_front();
        mv = (s >= 0);
        mb = (s == 1);
      end else begin
        mv = 0;
        if (acc) begin
          q.push_back(held);
          for (int i = 0; i < 7; i++) q.push_back(int'(in_data[i]));
          held = int'(in_data[7]);
          accepted = 1;
        end
      end
    end
    if (mv && nbits < 40) mdout = mb;
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    #1;
    cmp("R1", "in_ready", in_ready, (q.size() == 0) && minit);
    cmp("R2", "busy", busy, q.size() != 0);
    cmp("R4", "cfg_bit_vld", cfg_bit_vld, mv);
    if (mv) cmp("R3", "cfg_bit", cfg_bit, mb);
    cmp("R9", "init_n", init_n, minit);
    cmp("R8", "done", done, mdone);
    cmp("R8", "active", active, mact);
    if (!init_n) saw_low = 1;
    #2;
    cmp("R10", "dout", dout, mdout);
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    err_seen = 0; saw_low = 0;
    cmp("R1", "reset in_ready", in_ready, 1);
    cmp("R2", "reset busy", busy, 0);
    cmp("R8", "reset done", done, 0);
    cmp("R10", "reset dout", dout, 1);
  endtask

  task automatic send_byte(logic [7:0] b);
    if (err_seen) return;
    in_valid = 1; in_data = b;
    do tick(); while (!accepted && !err_seen);
    in_valid = 0;
  endtask

  task automatic add_hdr(int len, bit bad_pre, bit bad_sync);
    for (int i = 0; i < 8; i++) gb.push_back((bad_pre && i == 3) ? 0 : 1);
    for (int i = 0; i < 4; i++) gb.push_back(((SYNC >> i) & 1) ^ ((bad_sync && i == 2) ? 1 : 0));
    for (int i = 0; i < 24; i++) gb.push_back((len >> i) & 1);
    for (int i = 0; i < 4; i++) gb.push_back(1);
  endtask

  task automatic add_frame(bit bad_start, bit bad_stop);
    gb.push_back(bad_start ? 1 : 0);
    for (int i = 1; i < FRAME - 2; i++) gb.push_back(int'($urandom_range(1, 0)));
    gb.push_back(1);
    gb.push_back(bad_stop ? 0 : 1);
  endtask

  task automatic send_all(int gap);
    logic [7:0] b;
    while (gb.size() > 0) begin
      for (int i = 0; i < 8; i++) b[i] = (gb.size() > 0) ? 1'(gb.pop_front()) : 1'b1;
      send_byte(b);
      repeat (gap) tick();
    end
    gb.delete();
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // A: good stream, count ends inside a byte (R6, R7, R8)
    do_reset();
    add_hdr(572, 0, 0); add_frame(0, 0); add_frame(0, 0);
    send_all(0);
    repeat (20) tick();
    cmp("R6", "done after length", done, 1);
    cmp("R8", "active after length", active, 1);

    // B: broken preamble (R5)
    do_reset();
    add_hdr(900, 1, 0); add_frame(0, 0);
    send_all(1);
    repeat (20) tick();
    cmp("R5", "init_n pulse on preamble", saw_low, 1);
    cmp("R9", "done cleared", done, 0);

    // C: restart after error, last counted bit is a top bit (R4, R9)
    err_seen = 0; saw_low = 0;
    add_hdr(576, 0, 0); add_frame(0, 0); add_frame(0, 0);
    gb.push_back(0); gb.push_back(1); gb.push_back(1); gb.push_back(1);
    send_all(0);
    repeat (30) tick();
    cmp("R4", "done waits for held bit", done, 0);
    send_byte(8'hFF);
    repeat (10) tick();
    cmp("R4", "done after extra byte", done, 1);
    cmp("R9", "restart clean", saw_low, 0);

    // D: broken sync (R5)
    do_reset();
    add_hdr(900, 0, 1); add_frame(0, 0);
    send_all(0);
    repeat (20) tick();
    cmp("R5", "init_n pulse on sync", saw_low, 1);

    // E: bad stop bit in second frame (R7)
    err_seen = 0; saw_low = 0;
    add_hdr(900, 0, 0); add_frame(0, 0); add_frame(0, 1);
    send_all(2);
    repeat (20) tick();
    cmp("R7", "init_n pulse on stop bit", saw_low, 1);

    // F: bad start bit in first frame (R7)
    err_seen = 0; saw_low = 0;
    add_hdr(900, 0, 0); add_frame(1, 0);
    send_all(0);
    repeat (20) tick();
    cmp("R7", "init_n pulse on start bit", saw_low, 1);
    cmp("R9", "active cleared", active, 0);

    // G: shortest length after errors, with host gaps (R1, R6)
    err_seen = 0; saw_low = 0;
    add_hdr(41, 0, 0); gb.push_back(0);
    send_all(3);
    repeat (20) tick();
    cmp("R6", "done short length", done, 1);
    cmp("R8", "active short length", active, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule